// File: doc/BRIEF.md
# JTAG Debug-Bus Bridge

This block lets an external debugger reach a processor's debug module bus through a JTAG port. It sits behind a TAP controller that decodes the 4-bit instruction register and supplies Capture-DR, Shift-DR and Update-DR strobes. Three instruction codes select three data registers. The first is an 8-bit register that holds the debug-bus register number. The second is a 64-bit read register. The third is a 64-bit write register that shows the old value while the new value shifts in.

A capture on the read or write instruction starts a debug-bus read. The returned word is loaded into the shift register, so the debugger can then shift it out. An update on the write instruction starts a debug-bus write, using the latched address and the shifted word. The debug bus runs on the system clock. Each request crosses from the TCK domain as a toggle through a two-flop synchronizer, and each acknowledge comes back the same way. While a transfer is in flight, `dr_wait` is high, and the TAP driver must hold off shifting until it falls. All shifting is least significant bit first: TDI enters at the top bit of the selected register and TDO leaves from bit 0.

Top module: `jtag_dbus_bridge`

## Requirements
- R1: After trst_n or rst_n reset, dmi_req and dr_wait are low and the address register reads 0.
- R2: Instruction code 4'h8 selects the 8-bit address register. Capture loads its current value. Shifting is LSB first, with TDI entering bit 7 and TDO taken from bit 0. Update-DR latches the shifted value as the address.
- R3: Instruction code 4'h9 on Capture-DR issues one debug-bus read (dmi_we=0) at the latched address. The 64 returned bits then shift out LSB first.
- R4: dr_wait goes high in the TCK cycle after a read-type capture or a write update. It stays high until the acknowledge has come back through the synchronizer.
- R5: Instruction code 4'hA shifts out the current register value while the new value shifts in. Update-DR then issues one write (dmi_we=1) with the latched address and the 64 shifted bits.
- R6: Once raised, dmi_req stays high with stable dmi_we, dmi_addr and dmi_wdata until dmi_ack is sampled high.
- R7: Each capture or update that starts a transfer produces exactly one dmi_req pulse, and dmi_req drops in the cycle after the acknowledge.
- R8: Any other instruction code issues no debug-bus request and leaves the address register unchanged.
- R9: tap_reset clears the address register and drops dr_wait, abandoning a transfer in flight. A late acknowledge from that transfer has no effect.
- R10: Update-DR under the read instruction issues no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | JTAG test clock |
| trst_n | input | 1 | Asynchronous TCK-domain reset, active low |
| tap_reset | input | 1 | TAP is in Test-Logic-Reset |
| ir | input | 4 | Current instruction register value |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of the shift register) |
| dr_wait | output | 1 | A debug-bus transfer is in flight; hold off shifting |
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| dmi_req | output | 1 | Debug-bus request |
| dmi_we | output | 1 | Request is a write |
| dmi_addr | output | 8 | Debug-bus register number |
| dmi_wdata | output | 64 | Write data |
| dmi_ack | input | 1 | Debug-bus acknowledge |
| dmi_rdata | input | 64 | Read data, valid with dmi_ack |

## Verification
The bench builds the block with its defaults: an 8-bit address, 64-bit data and the codes 8, 9 and A. A behavioural debug bus with varying acknowledge latency stands behind it. With those values, 24 addresses spread across the whole 8-bit range each get an address load, a read, a write-with-readback and a re-read. This covers every shift length and the wait under slow TCK against fast system-clock ratios. Stray instruction codes, read-side updates, and a TAP reset during an unanswered request are also in reach.

// File: rtl/jtag_dbus_bridge.sv
module jtag_dbus_bridge #(
  parameter int IRW = 4,
  parameter int AW = 8,
  parameter int DW = 64,
  parameter logic [IRW-1:0] IR_ADDR = 4'h8,
  parameter logic [IRW-1:0] IR_READ = 4'h9,
  parameter logic [IRW-1:0] IR_WRRD = 4'hA
) (
  input  logic           tck,
  input  logic           trst_n,
  input  logic           tap_reset,
  input  logic [IRW-1:0] ir,
  input  logic           capture_dr,
  input  logic           shift_dr,
  input  logic           update_dr,
  input  logic           tdi,
  output logic           tdo,
  output logic           dr_wait,
  input  logic           clk,
  input  logic           rst_n,
  output logic           dmi_req,
  output logic           dmi_we,
  output logic [AW-1:0]  dmi_addr,
  output logic [DW-1:0]  dmi_wdata,
  input  logic           dmi_ack,
  input  logic [DW-1:0]  dmi_rdata
);

  logic [DW-1:0] sr;
  logic [AW-1:0] addr_q;
  logic          op_we, req_tgl, ack_tgl;
  logic [2:0]    ack_s, req_s;
  logic [DW-1:0] rdata_q;
  logic          ack_edge, req_edge;

  assign tdo      = sr[0];
  assign ack_edge = ack_s[2] ^ ack_s[1];
  assign req_edge = req_s[2] ^ req_s[1];

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) ack_s <= '0;
    else         ack_s <= {ack_s[1:0], ack_tgl};

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr <= '0; addr_q <= '0; op_we <= 1'b0; req_tgl <= 1'b0; dr_wait <= 1'b0;
    end else if (tap_reset) begin
      addr_q  <= '0;
      dr_wait <= 1'b0;
    end else if (dr_wait) begin
      if (ack_edge) begin
        dr_wait <= 1'b0;
        if (!op_we) sr <= rdata_q;
      end
    end else if (capture_dr) begin
      if (ir == IR_ADDR) sr <= {{(DW-AW){1'b0}}, addr_q};
      else if (ir == IR_READ || ir == IR_WRRD) begin
        req_tgl <= ~req_tgl;
        op_we   <= 1'b0;
        dr_wait <= 1'b1;
      end else sr <= '0;
    end else if (shift_dr) begin
      if (ir == IR_ADDR)                       sr <= {{(DW-AW){1'b0}}, tdi, sr[AW-1:1]};
      else if (ir == IR_READ || ir == IR_WRRD) sr <= {tdi, sr[DW-1:1]};
      else                                     sr <= {{(DW-1){1'b0}}, tdi};
    end else if (update_dr) begin
      if (ir == IR_ADDR) addr_q <= sr[AW-1:0];
      else if (ir == IR_WRRD) begin
        req_tgl <= ~req_tgl;
        op_we   <= 1'b1;
        dr_wait <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_s <= '0; ack_tgl <= 1'b0; dmi_req <= 1'b0; dmi_we <= 1'b0;
      dmi_addr <= '0; dmi_wdata <= '0; rdata_q <= '0;
    end else begin
      req_s <= {req_s[1:0], req_tgl};
      if (dmi_req) begin
        if (dmi_ack) begin
          dmi_req <= 1'b0;
          rdata_q <= dmi_rdata;
          ack_tgl <= ~ack_tgl;
        end
      end else if (req_edge) begin
        dmi_req   <= 1'b1;
        dmi_we    <= op_we;
        dmi_addr  <= addr_q;
        dmi_wdata <= sr;
      end
    end
  end

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dmi_req && !dmi_ack |=> dmi_req);
  assert_payload_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dmi_req && !dmi_ack |=> $stable(dmi_we) && $stable(dmi_addr) && $stable(dmi_wdata));
  assert_req_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dmi_req && dmi_ack |=> !dmi_req);
  assert_wait_hold_R4: assert property (@(posedge tck) disable iff (!trst_n || tap_reset)
    dr_wait && !ack_edge |=> dr_wait);
  assert_reset_clears_R9: assert property (@(posedge tck) disable iff (!trst_n)
    tap_reset |=> !dr_wait);

endmodule

// File: tb/jtag_dbus_bridge_tb.sv
`timescale 1ns/1ps
module jtag_dbus_bridge_tb;
  logic tck = 0, clk = 0, trst_n = 0, rst_n = 0, tap_reset = 0;
  logic [3:0] ir = 0;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
  logic tdo, dr_wait, dmi_req, dmi_we, dmi_ack = 0;
  logic [7:0] dmi_addr;
  logic [63:0] dmi_wdata, dmi_rdata = 0;

  int checks = 0, errors = 0, nreq = 0, cyc = 0, cnt = 0;
  logic hold_ack = 0, prev_req = 0, last_we = 0;
  logic [7:0] last_addr = 0;
  logic [63:0] last_wdata = 0;
  logic [63:0] mem [256];
  logic [63:0] expm [256];

  always #2.5 clk = ~clk;
  always #20 tck = ~tck;

  jtag_dbus_bridge u_dut (.tck(tck), .trst_n(trst_n), .tap_reset(tap_reset), .ir(ir),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi),
    .tdo(tdo), .dr_wait(dr_wait), .clk(clk), .rst_n(rst_n), .dmi_req(dmi_req),
    .dmi_we(dmi_we), .dmi_addr(dmi_addr), .dmi_wdata(dmi_wdata), .dmi_ack(dmi_ack),
    .dmi_rdata(dmi_rdata));

  function automatic logic [63:0] init_val(int a);
    return {8{a[7:0]}} ^ 64'hA5C3_0F1E_9B27_4D86;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (dmi_req && !prev_req) begin
        nreq++; last_we = dmi_we; last_addr = dmi_addr; last_wdata = dmi_wdata;
      end
      prev_req = dmi_req;
      if (dmi_ack) dmi_ack = 0;
      else if (dmi_req && !hold_ack) begin
        if (cnt >= (nreq % 4)) begin
          dmi_ack = 1; dmi_rdata = mem[dmi_addr];
          if (dmi_we) mem[dmi_addr] = dmi_wdata;
          cnt = 0;
        end else cnt++;
      end
    end
  end

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++; $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      finish_up();
    end
  end

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++; $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic capture(logic [3:0] code, bit wait_done, output logic waited);
    @(negedge tck); ir = code; capture_dr = 1;
    @(negedge tck); capture_dr = 0; waited = dr_wait;
    if (wait_done) while (dr_wait) @(negedge tck);
  endtask

  task automatic shift(int n, logic [63:0] din, output logic [63:0] dout);
    dout = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge tck); dout[i] = tdo; tdi = din[i]; shift_dr = 1;
    end
    @(negedge tck); shift_dr = 0;
  endtask

  task automatic update;
    @(negedge tck); update_dr = 1;
    @(negedge tck); update_dr = 0;
    while (dr_wait) @(negedge tck);
  endtask

  task automatic set_addr(logic [7:0] a, output logic [7:0] old);
    logic w; logic [63:0] d;
    capture(4'h8, 1, w); shift(8, {56'd0, a}, d); old = d[7:0]; update();
  endtask

  task automatic do_read(output logic [63:0] d, output logic w);
    capture(4'h9, 1, w); shift(64, 64'd0, d);
  endtask

  initial begin
    logic [7:0] olda, expa;
    logic [63:0] d, nv;
    logic w;
    int n0;
    for (int i = 0; i < 256; i++) begin mem[i] = init_val(i); expm[i] = init_val(i); end
    #33 trst_n = 1; rst_n = 1;
    @(negedge tck);
    chk("R1 dmi_req", dmi_req, 0);
    chk("R1 dr_wait", dr_wait, 0);
    expa = 0;
    for (int k = 0; k < 24; k++) begin
      logic [7:0] a;
      a = 8'(k * 11);
      n0 = nreq;
      set_addr(a, olda);
      chk(k == 0 ? "R1 addr reset value" : "R2 addr readback", olda, expa);
      chk("R8-like R2 no request on addr", nreq, n0);
      expa = a;
      do_read(d, w);
      chk("R3 read data", d, expm[a]);
      chk("R4 wait after capture", w, 1);
      chk("R7 one read request", nreq, n0 + 1);
      chk("R3 read addr/we", {last_addr, 7'd0, last_we}, {a, 8'd0});
      nv = {8{a ^ 8'hFF}} + 64'(k);
      capture(4'hA, 1, w); shift(64, nv, d);
      chk("R5 readback old", d, expm[a]);
      update();
      chk("R7 write request count", nreq, n0 + 3);
      chk("R5 write addr/we", {last_addr, 7'd0, last_we}, {a, 8'd1});
      chk("R5 write data", last_wdata, nv);
      expm[a] = nv;
      do_read(d, w);
      chk("R5 reread", d, nv);
    end
    n0 = nreq;
    do_read(d, w); update();
    chk("R10 no write on read update", nreq, n0 + 1);
    chk("R10 last op read", last_we, 0);
    n0 = nreq;
    capture(4'h3, 1, w); shift(16, 64'hBEEF, d); update();
    chk("R8 other code no request", nreq, n0);
    set_addr(expa, olda);
    chk("R8 addr unchanged", olda, expa);
    set_addr(8'h5C, olda);
    @(negedge tck); tap_reset = 1;
    @(negedge tck); tap_reset = 0;
    set_addr(8'h12, olda);
    chk("R9 addr cleared", olda, 0);
    hold_ack = 1;
    capture(4'h9, 0, w);
    chk("R4 wait while unanswered", w, 1);
    repeat (5) @(negedge tck);
    chk("R4 wait held", dr_wait, 1);
    tap_reset = 1; @(negedge tck); tap_reset = 0;
    chk("R9 wait dropped", dr_wait, 0);
    hold_ack = 0;
    repeat (10) @(negedge tck);
    chk("R9 late ack ignored", dr_wait, 0);
    set_addr(8'h12, olda);
    chk("R9 addr after abandon", olda, 0);
    do_read(d, w);
    chk("R9 bridge usable after abandon", d, expm[8'h12]);
    finish_up();
  end
endmodule